// File: doc/BRIEF.md
# Status-Coded I2C Master Transmitter

This block is a byte-level I2C bus master that a host drives one step at a time through four small registers. The host enables the block and requests a START. The block waits until no other master holds the bus and then issues the START condition. After that it shifts out one byte for each release the host gives it: first the address with its direction bit, then data bytes. Each byte ends with the acknowledge slot.

After every bus event the block raises a serial-interrupt flag and posts an eight-bit status code. It then keeps SCL low until the host clears the flag. The host therefore decides the next step from the code alone: send another byte, or finish with a STOP. The block clears the STOP request on its own once the STOP is on the wire.

Both bus lines are open-drain. The block drives a pull-low enable for each line and samples each line through a synchronizer. A programmable divider sets the SCL timing. Bus occupancy is tracked by watching for START and STOP patterns on the lines.

Top module: `i2c_coded_master`

## Requirements
- R1: After reset, status reads 0xF8, the control register reads 0x00, the interrupt output is low and neither line is pulled low.
- R2: With enable (control bit 0) and start request (control bit 1) set on a free bus, SDA falls while SCL is high. SCL is then pulled low, the interrupt flag (control bit 3) sets, status becomes 0x08 and the start request bit clears itself.
- R3: A start request made after a START on the bus and before the matching STOP causes no bus activity. The START is issued only after the STOP has been observed.
- R4: While the interrupt flag is set, SCL is held low and SDA does not change.
- R5: Clearing the flag with stop request (control bit 2) low shifts the data register (address 1) out MSB first. There are eight SCL pulses and then a ninth acknowledge pulse, and SDA changes only while SCL is low.
- R6: For the first byte after a START, status becomes 0x18 when the receiver pulls SDA low in the ninth slot (ACK) and 0x20 when it leaves SDA high (NACK).
- R7: For every later byte, ACK gives status 0x28 and NACK gives status 0x30.
- R8: Clearing the flag with stop request set drives SDA low and releases SCL, then releases SDA while SCL is high (STOP). Both lines are then released, the stop request bit clears itself, status becomes 0xF8 and the flag stays low.
- R9: Every SCL high period in a byte lasts 2*(D+1) clock cycles, where D is the divider register (address 3).
- R10: Writing 1 to the flag bit of the control register (address 0) never sets it. Writing 0 clears it.
- R11: A start request with enable low produces no bus activity and no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 data, 2 status, 3 divider |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data of the selected register |
| irq | output | 1 | Serial-interrupt flag |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
Two situations cannot be reached through the register port alone: a bus already held by another master, and a receiver that answers the acknowledge slot. The bench handles the first by pulling SDA low itself while SCL idles high, which looks like a foreign START. It holds that state while a start request is pending and releases SDA later, which produces a STOP. For the second, a small responder model counts SCL edges, captures each byte and pulls SDA low in the ninth slot or not, as each vector asks. This lets every one of the four acknowledge codes be produced on demand.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {PH_IDLE, PH_START, PH_HOLD, PH_BIT, PH_STOP} phase_e;

  localparam logic [7:0] CODE_START     = 8'h08;
  localparam logic [7:0] CODE_ADDR_ACK  = 8'h18;
  localparam logic [7:0] CODE_ADDR_NACK = 8'h20;
  localparam logic [7:0] CODE_DATA_ACK  = 8'h28;
  localparam logic [7:0] CODE_DATA_NACK = 8'h30;
  localparam logic [7:0] CODE_IDLE      = 8'hF8;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_DATA = 2'd1;
  localparam logic [1:0] REG_STAT = 2'd2;
  localparam logic [1:0] REG_DIV  = 2'd3;

  localparam int CB_EN  = 0;
  localparam int CB_STA = 1;
  localparam int CB_STO = 2;
  localparam int CB_SI  = 3;
  localparam int CB_AA  = 4;
endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= div) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/i2cm_busmon.sv
module i2cm_busmon #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic busy
);
  logic [SYNC-1:0] scl_q, sda_q;
  logic scl_s, scl_p, sda_p;
  logic start_det, stop_det;

  assign scl_s = scl_q[SYNC-1];
  assign sda_s = sda_q[SYNC-1];
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
      busy  <= 1'b0;
    end else begin
      scl_q <= {scl_q[SYNC-2:0], scl_i};
      sda_q <= {sda_q[SYNC-2:0], sda_i};
      scl_p <= scl_s;
      sda_p <= sda_s;
      if (start_det)     busy <= 1'b1;
      else if (stop_det) busy <= 1'b0;
    end
  end

  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    start_det |=> busy);

  // R3
  stop_free_chk: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !busy);
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
  import i2cm_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        tick,
  input  logic        go_start,
  input  logic        si,
  input  logic        sto,
  input  logic [BYTE_W-1:0] data,
  input  logic        sda_s,
  output logic        scl_oe,
  output logic        sda_oe,
  output logic        ev_valid,
  output logic [7:0]  ev_code,
  output logic        sta_clr,
  output logic        stop_done
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);

  phase_e            st;
  logic [1:0]        q;
  logic [CNT_W-1:0]  bitn;
  logic [BYTE_W-1:0] sh;
  logic              first, guard;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= PH_IDLE;
      q         <= 2'd0;
      bitn      <= '0;
      sh        <= '0;
      first     <= 1'b0;
      guard     <= 1'b0;
      scl_oe    <= 1'b0;
      sda_oe    <= 1'b0;
      ev_valid  <= 1'b0;
      ev_code   <= CODE_IDLE;
      sta_clr   <= 1'b0;
      stop_done <= 1'b0;
    end else begin
      ev_valid  <= 1'b0;
      sta_clr   <= 1'b0;
      stop_done <= 1'b0;
      case (st)
        PH_IDLE: begin
          scl_oe <= 1'b0;
          sda_oe <= 1'b0;
          q      <= 2'd0;
          if (tick && go_start) st <= PH_START;
        end
        PH_START: if (tick) begin
          q <= q + 2'd1;
          case (q)
            2'd0: sda_oe <= 1'b1;
            2'd2: scl_oe <= 1'b1;
            2'd3: begin
              st       <= PH_HOLD;
              guard    <= 1'b1;
              first    <= 1'b1;
              ev_valid <= 1'b1;
              ev_code  <= CODE_START;
              sta_clr  <= 1'b1;
            end
            default: ;
          endcase
        end
        PH_HOLD: begin
          q <= 2'd0;
          if (guard) guard <= 1'b0;
          else if (tick && !si) begin
            if (sto) st <= PH_STOP;
            else begin
              st   <= PH_BIT;
              bitn <= '0;
              sh   <= data;
            end
          end
        end
        PH_BIT: if (tick) begin
          q <= q + 2'd1;
          case (q)
            2'd0: sda_oe <= (bitn == ACK_SLOT) ? 1'b0 : ~sh[BYTE_W-1];
            2'd1: scl_oe <= 1'b0;
            2'd3: begin
              scl_oe <= 1'b1;
              if (bitn == ACK_SLOT) begin
                st       <= PH_HOLD;
                guard    <= 1'b1;
                first    <= 1'b0;
                ev_valid <= 1'b1;
                ev_code  <= first ? (sda_s ? CODE_ADDR_NACK : CODE_ADDR_ACK)
                                  : (sda_s ? CODE_DATA_NACK : CODE_DATA_ACK);
              end else begin
                sh   <= {sh[BYTE_W-2:0], 1'b0};
                bitn <= bitn + 1'b1;
              end
            end
            default: ;
          endcase
        end
        PH_STOP: if (tick) begin
          q <= q + 2'd1;
          case (q)
            2'd0: sda_oe <= 1'b1;
            2'd1: scl_oe <= 1'b0;
            2'd3: begin
              sda_oe    <= 1'b0;
              st        <= PH_IDLE;
              stop_done <= 1'b1;
            end
            default: ;
          endcase
        end
        default: st <= PH_IDLE;
      endcase
    end
  end

  // R4
  hold_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    (st == PH_HOLD) |-> scl_oe);

  // R5
  sda_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (st == PH_BIT && $past(st) == PH_BIT && sda_oe != $past(sda_oe))
      |-> (scl_oe && $past(scl_oe)));

  // R8
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    stop_done |-> (!scl_oe && !sda_oe && st == PH_IDLE));
endmodule

// File: rtl/i2c_coded_master.sv
module i2c_coded_master
  import i2cm_pkg::*;
#(
  parameter int              DIV_W   = 8,
  parameter logic [DIV_W-1:0] DIV_RST = DIV_W'(9),
  parameter int              SYNC    = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reg_we,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe
);
  logic             en, sta, sto, si, aa;
  logic [7:0]       data_r, status_r;
  logic [DIV_W-1:0] div_r;
  logic             tick, sda_s, busy;
  logic             ev_valid, sta_clr, stop_done;
  logic [7:0]       ev_code;

  i2cm_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .div(div_r), .tick(tick)
  );

  i2cm_busmon #(.SYNC(SYNC)) u_mon (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .busy(busy)
  );

  i2cm_engine u_eng (
    .clk(clk), .rst(rst), .tick(tick),
    .go_start(en & sta & ~si & ~busy),
    .si(si), .sto(sto), .data(data_r), .sda_s(sda_s),
    .scl_oe(scl_oe), .sda_oe(sda_oe),
    .ev_valid(ev_valid), .ev_code(ev_code),
    .sta_clr(sta_clr), .stop_done(stop_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en        <= 1'b0;
      sta       <= 1'b0;
      sto       <= 1'b0;
      si        <= 1'b0;
      aa        <= 1'b0;
      data_r    <= '0;
      status_r  <= CODE_IDLE;
      div_r     <= DIV_RST;
      reg_rdata <= '0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          REG_CTRL: begin
            en  <= reg_wdata[CB_EN];
            sta <= reg_wdata[CB_STA];
            sto <= reg_wdata[CB_STO];
            aa  <= reg_wdata[CB_AA];
            if (!reg_wdata[CB_SI]) si <= 1'b0;
          end
          REG_DATA: data_r <= reg_wdata;
          REG_DIV:  div_r  <= DIV_W'(reg_wdata);
          default: ;
        endcase
      end
      if (ev_valid) begin
        si       <= 1'b1;
        status_r <= ev_code;
      end
      if (sta_clr) sta <= 1'b0;
      if (stop_done) begin
        sto      <= 1'b0;
        status_r <= CODE_IDLE;
      end
      case (reg_addr)
        REG_CTRL: reg_rdata <= {3'b000, aa, si, sto, sta, en};
        REG_DATA: reg_rdata <= data_r;
        REG_STAT: reg_rdata <= status_r;
        default:  reg_rdata <= 8'(div_r);
      endcase
    end
  end

  assign irq = si;

  // R10
  si_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(si) |-> $past(ev_valid));

  // R2
  sta_auto_clr_chk: assert property (@(posedge clk) disable iff (rst)
    sta_clr |=> !sta);

  // R8
  sto_auto_clr_chk: assert property (@(posedge clk) disable iff (rst)
    stop_done |=> (!sto && status_r == CODE_IDLE));
endmodule

// File: tb/i2c_coded_master_test.sv
`timescale 1ns/1ps
module i2c_coded_master_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic irq, scl_oe, sda_oe;
  logic slv_pull = 1'b0;
  logic ext_pull = 1'b0;
  logic ack_want = 1'b1;
  logic scl, sda;

  int checks = 0, failures = 0, cyc = 0;
  int starts = 0, stops = 0, bitc = 0, hi_cnt = 0, hi_len = 0;
  logic [7:0] rx = 8'h00, rx_last = 8'h00;
  logic sp = 1'b1, dp = 1'b1;
  logic [7:0] r;

  always #2 clk = ~clk;

  assign scl = ~scl_oe;
  assign sda = ~(sda_oe | slv_pull | ext_pull);

  i2c_coded_master uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_i(scl), .sda_i(sda), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  // responder and bus observer
  always @(negedge clk) begin
    if (sp && scl && dp && !sda) begin bitc <= 0; starts <= starts + 1; end
    else if (sp && scl && !dp && sda) stops <= stops + 1;
    if (!sp && scl) begin
      if (bitc < 8) rx <= {rx[6:0], sda};
      bitc <= bitc + 1;
      hi_cnt <= 1;
    end else if (scl) hi_cnt <= hi_cnt + 1;
    if (sp && !scl) begin
      hi_len <= hi_cnt;
      if (bitc == 8) begin slv_pull <= ack_want; rx_last <= rx; end
      else if (bitc == 9) begin slv_pull <= 1'b0; bitc <= 0; end
    end
    sp <= scl;
    dp <= sda;
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      $display("FAIL watchdog act=%0d exp=below_150000", cyc);
      failures = failures + 1;
      checks = checks + 1;
      summary();
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      failures = failures + 1;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 5000 && !irq; i++) @(negedge clk);
  endtask

  task automatic do_start();
    int s0;
    s0 = starts;
    wr(2'd0, 8'h03);
    wait_irq();
    rd(2'd2, r);
    chk("R2 status", r, 8'h08);
    rd(2'd0, r);
    chk("R2 ctrl sta cleared si set", r, 8'h09);
    chk("R2 start seen", starts - s0, 1);
    chk("R2 scl held", scl_oe, 1);
  endtask

  task automatic do_stop();
    int p0;
    p0 = stops;
    wr(2'd0, 8'h05);
    r = 8'h04;
    for (int i = 0; i < 2000 && r[2]; i++) rd(2'd0, r);
    repeat (8) @(negedge clk);
    chk("R8 sto self clear", r[2], 0);
    rd(2'd2, r);
    chk("R8 status", r, 8'hF8);
    chk("R8 stop seen", stops - p0, 1);
    chk("R8 irq low", irq, 0);
    chk("R8 lines released", {scl_oe, sda_oe}, 0);
  endtask

  task automatic send(input logic [7:0] d, input logic ak, input logic [7:0] exp, input string tag);
    wr(2'd1, d);
    ack_want = ak;
    wr(2'd0, 8'h01);
    wait_irq();
    rd(2'd2, r);
    chk(tag, r, exp);
    chk("R5 byte on wire", rx_last, d);
    chk("R4 scl held after byte", scl_oe, 1);
  endtask

  // {restart, data, ack, expected status}
  localparam logic [17:0] VEC [0:5] = '{
    {1'b1, 8'hA6, 1'b1, 8'h18},
    {1'b0, 8'h3C, 1'b1, 8'h28},
    {1'b0, 8'hFF, 1'b0, 8'h30},
    {1'b0, 8'h01, 1'b1, 8'h28},
    {1'b1, 8'h51, 1'b0, 8'h20},
    {1'b0, 8'h80, 1'b1, 8'h28}
  };

  initial begin
    int s0, hi_seen;
    logic [7:0] data_before;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 lines", {scl_oe, sda_oe}, 0);
    rd(2'd2, r); chk("R1 status", r, 8'hF8);
    rd(2'd0, r); chk("R1 ctrl", r, 8'h00);

    wr(2'd3, 8'd3);

    // R11 start request ignored while disabled
    s0 = starts;
    wr(2'd0, 8'h02);
    repeat (100) @(negedge clk);
    chk("R11 no start", starts - s0, 0);
    chk("R11 no irq", irq, 0);
    chk("R11 lines", {scl_oe, sda_oe}, 0);
    wr(2'd0, 8'h00);

    // R10 flag cannot be set by the host
    wr(2'd0, 8'h08);
    rd(2'd0, r);
    chk("R10 si not set", r[3], 0);
    chk("R10 irq low", irq, 0);
    wr(2'd0, 8'h00);

    // table walk: R5 R6 R7
    for (int i = 0; i < 6; i++) begin
      if (VEC[i][17]) begin
        if (i != 0) do_stop();
        do_start();
      end
      send(VEC[i][16:9], VEC[i][8], VEC[i][7:0],
           (i == 0 || i == 4) ? "R6 addr status" : "R7 data status");
      if (i == 0) chk("R9 high period div3", hi_len, 8);
    end

    // R4 hold: SCL stays low and SDA steady while flag is set
    hi_seen = 0;
    data_before = {7'd0, sda};
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (scl || sda != data_before[0]) hi_seen = hi_seen + 1;
    end
    chk("R4 bus frozen while flagged", hi_seen, 0);
    do_stop();

    // R9 at another divider setting
    wr(2'd3, 8'd5);
    do_start();
    send(8'h5A, 1'b1, 8'h18, "R6 addr ack div5");
    chk("R9 high period div5", hi_len, 12);
    do_stop();
    wr(2'd3, 8'd3);

    // R3 bus held by another master
    ext_pull = 1'b1;
    repeat (20) @(negedge clk);
    s0 = starts;
    wr(2'd0, 8'h03);
    repeat (200) @(negedge clk);
    chk("R3 waits while busy", {scl_oe, sda_oe, irq}, 0);
    rd(2'd2, r); chk("R3 status idle", r, 8'hF8);
    ext_pull = 1'b0;
    wait_irq();
    rd(2'd2, r); chk("R3 start after stop", r, 8'h08);
    chk("R3 own start on wire", starts - s0, 1);
    send(8'hC3, 1'b0, 8'h20, "R6 addr nack after busy");
    do_stop();

    summary();
    $finish;
  end
endmodule